// File: doc/BRIEF.md
# Intrusion Alarm Controller with Entry-Delay Display

This block watches three intrusion sensors (front door, rear door, window) on behalf of a single arm switch. Once armed, any sensor activity starts an entry delay of seven one-second ticks. During that delay the elapsed seconds are shown on one seven-segment digit, which gives the occupant time to disarm. If the delay runs out, the siren sounds and stays on until the arm switch is dropped. Dropping the arm switch clears the controller at once, without waiting for a clock edge, whatever it is doing.

Everything runs from one fast system clock. A prescaler makes a one-cycle tick every `TICK_DIV` clocks (50,000,000 by default, which gives 1 Hz at 50 MHz), and that tick is used as a clock enable. The arm and sensor inputs pass through two-flop synchronizers before the sequencer uses them. Four indicator outputs echo the raw switch and sensor levels so they can drive status lamps.

Top module: `intrusion_alarm_top`

## Requirements
- R1: While arm_sw is low, siren is low, seg_n shows digit 0 (0x03) and digit_en_n is 4'b1110, whatever the sensors do.
- R2: After arm_sw rises with all sensors low, siren stays low and the display stays at 0 for as long as the sensors stay low.
- R3: While armed, any nonzero combination of the sensors (vector order front, rear, window) starts the entry delay. The display then steps through 0,1,...,7 in order, one step per tick.
- R4: After seven ticks of entry delay the siren rises. With two synchronizer stages and one state update, this happens between 6*TICK_DIV and 7*TICK_DIV+5 cycles after a sensor rises.
- R5: Once the siren is on, it stays on while arm_sw is high, even when all sensors are released, and the display returns to 0.
- R6: A falling arm_sw clears the controller asynchronously: before the next clock edge, siren is low and the display shows 0, from the entry delay and from the alarm alike.
- R7: Releasing the sensors during the entry delay does not cancel it.
- R8: ind_arm, ind_front, ind_rear and ind_window follow arm_sw, sens_front, sens_rear and sens_window combinationally.
- R9: Segments are active low, with seg_n[7:0] = a,b,c,d,e,f,g,dp from MSB to LSB. Digits 0..7 encode as 0x03, 0x9F, 0x25, 0x0D, 0x99, 0x49, 0x41, 0x1F.
- R10: The tick is a single-cycle pulse exactly every TICK_DIV cycles, so successive display steps during the delay are TICK_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| arm_sw | input | 1 | Arm switch; low disarms asynchronously |
| sens_front | input | 1 | Front door sensor, high = open |
| sens_rear | input | 1 | Rear door sensor, high = open |
| sens_window | input | 1 | Window sensor, high = open |
| siren | output | 1 | High while the alarm sounds |
| ind_arm | output | 1 | Echo of arm_sw |
| ind_front | output | 1 | Echo of sens_front |
| ind_rear | output | 1 | Echo of sens_rear |
| ind_window | output | 1 | Echo of sens_window |
| seg_n | output | 8 | Active-low segments a..g,dp (MSB..LSB) |
| digit_en_n | output | 4 | Active-low digit enables, only digit 0 lit |

## Verification
The hardest situation to reach from the ports is an asynchronous disarm that lands at an arbitrary point inside the entry delay or inside the alarm. The bench therefore draws the disarm cycle at random over the whole delay window and checks the outputs one nanosecond after arm_sw falls, before any clock edge. The tick and the delay counter are not visible at the ports, so the bench infers them from the display. It records the cycle of each digit change and checks the order of the digits, the spacing between them and the siren window against values it computes itself. A small tick divisor keeps each episode short.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_WATCH = 2'd1,
      ST_ENTRY = 2'd2,
      ST_SOUND = 2'd3
   } alarm_state_e;

   // active-high segment pattern, bit order a,b,c,d,e,f,g,dp (MSB..LSB)
   function automatic logic [7:0] hex_segments(input logic [3:0] v);
      logic [7:0] s;
      case (v)
         4'h0: s = 8'hFC;
         4'h1: s = 8'h60;
         4'h2: s = 8'hDA;
         4'h3: s = 8'hF2;
         4'h4: s = 8'h66;
         4'h5: s = 8'hB6;
         4'h6: s = 8'hBE;
         4'h7: s = 8'hE0;
         4'h8: s = 8'hFE;
         4'h9: s = 8'hF6;
         4'hA: s = 8'hEE;
         4'hB: s = 8'h3E;
         4'hC: s = 8'h9C;
         4'hD: s = 8'h7A;
         4'hE: s = 8'h9E;
         default: s = 8'h8E;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/in_sync.sv
module in_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("in_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("in_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) pipe[i] <= '0;
            else        pipe[i] <= d;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) pipe[i] <= '0;
            else        pipe[i] <= pipe[i-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
   parameter int TICK_DIV = 50_000_000
) (
   input  logic clk,
   input  logic clr_n,
   output logic tick
);
   if (TICK_DIV < 2) begin : g_bad_div
      $error("tick_gen: TICK_DIV must be at least 2");
   end

   localparam int CW = $clog2(TICK_DIV);
   localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

   logic [CW-1:0] cnt_q;
   logic          tick_q;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q  <= '0;
         tick_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         tick_q <= 1'b0;
      end
   end

   assign tick = tick_q;
endmodule

// File: rtl/alarm_seq.sv
module alarm_seq
   import alarm_pkg::*;
#(
   parameter int NUM_SENSORS = 3,
   parameter int DELAY_W     = 3,
   parameter int DELAY_LAST  = 7
) (
   input  logic                   clk,
   input  logic                   arm_raw,
   input  logic                   arm_s,
   input  logic [NUM_SENSORS-1:0] sens_s,
   input  logic                   tick,
   output alarm_state_e           state,
   output logic [DELAY_W-1:0]     dly,
   output logic                   run_timer,
   output logic                   siren
);
   if (DELAY_LAST < 1 || DELAY_LAST >= (1 << DELAY_W)) begin : g_bad_delay
      $error("alarm_seq: DELAY_LAST must fit in DELAY_W bits and be nonzero");
   end

   localparam logic [DELAY_W-1:0] LAST = DELAY_W'(DELAY_LAST);

   alarm_state_e       state_q, state_d;
   logic [DELAY_W-1:0] dly_q;
   logic               dly_done;

   assign dly_done = (dly_q == LAST);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_OFF:   if (arm_s)       state_d = ST_WATCH;
         ST_WATCH: if (|sens_s)     state_d = ST_ENTRY;
         ST_ENTRY: if (dly_done)    state_d = ST_SOUND;
                   else if (!arm_s) state_d = ST_OFF;
         ST_SOUND: if (!arm_s)      state_d = ST_OFF;
         default:                   state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge arm_raw) begin
      if (!arm_raw) state_q <= ST_OFF;
      else          state_q <= state_d;
   end

   // entry-delay seconds, cleared outside the delay state
   always_ff @(posedge clk or negedge arm_raw) begin
      if (!arm_raw)                dly_q <= '0;
      else if (state_q != ST_ENTRY) dly_q <= '0;
      else if (tick && !dly_done)  dly_q <= dly_q + 1'b1;
   end

   assign state     = state_q;
   assign dly       = dly_q;
   assign run_timer = (state_q == ST_ENTRY);
   assign siren     = (state_q == ST_SOUND);
endmodule

// File: rtl/sec_display.sv
module sec_display
   import alarm_pkg::*;
#(
   parameter int SEC_W          = 4,
   parameter int NUM_DIGITS     = 4,
   parameter int LIVE_DIGIT     = 0,
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input  logic                  clk,
   input  logic                  clr_n,
   input  logic                  run,
   input  logic                  tick,
   output logic [SEC_W-1:0]      sec,
   output logic [7:0]            seg_n,
   output logic [NUM_DIGITS-1:0] digit_en_n
);
   if (SEC_W < 4) begin : g_bad_sec
      $error("sec_display: SEC_W must be at least 4");
   end
   if (LIVE_DIGIT < 0 || LIVE_DIGIT >= NUM_DIGITS) begin : g_bad_digit
      $error("sec_display: LIVE_DIGIT out of range");
   end

   logic [SEC_W-1:0] sec_q;
   logic [7:0]       seg_on;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)    sec_q <= '0;
      else if (!run) sec_q <= '0;
      else if (tick) sec_q <= sec_q + 1'b1;
   end

   assign seg_on = hex_segments(sec_q[3:0]);

   if (SEG_ACTIVE_LOW) begin : g_seg_low
      assign seg_n = ~seg_on;
   end else begin : g_seg_high
      assign seg_n = seg_on;
   end

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
      assign digit_en_n[i] = (i == LIVE_DIGIT) ? 1'b0 : 1'b1;
   end

   assign sec = sec_q;
endmodule

// File: rtl/intrusion_alarm_top.sv
module intrusion_alarm_top
   import alarm_pkg::*;
#(
   parameter int TICK_DIV    = 50_000_000,
   parameter int SYNC_STAGES = 2,
   parameter int DELAY_W     = 3,
   parameter int DELAY_LAST  = 7,
   parameter int SEC_W       = 4
) (
   input  logic       clk,
   input  logic       arm_sw,
   input  logic       sens_front,
   input  logic       sens_rear,
   input  logic       sens_window,
   output logic       siren,
   output logic       ind_arm,
   output logic       ind_front,
   output logic       ind_rear,
   output logic       ind_window,
   output logic [7:0] seg_n,
   output logic [3:0] digit_en_n
);
   localparam int NUM_SENSORS = 3;
   localparam int NUM_DIGITS  = 4;
   localparam int SYNC_W      = NUM_SENSORS + 1;

   logic [SYNC_W-1:0]      raw_in, sync_out;
   logic                   arm_s;
   logic [NUM_SENSORS-1:0] sens_s;
   logic                   tick;
   alarm_state_e           state;
   logic [DELAY_W-1:0]     dly;
   logic                   run_timer;
   logic [SEC_W-1:0]       sec;

   assign raw_in = {arm_sw, sens_front, sens_rear, sens_window};

   in_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .clr_n (arm_sw),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign arm_s  = sync_out[SYNC_W-1];
   assign sens_s = sync_out[NUM_SENSORS-1:0];

   tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .clr_n (arm_sw),
      .tick  (tick)
   );

   alarm_seq #(
      .NUM_SENSORS (NUM_SENSORS),
      .DELAY_W     (DELAY_W),
      .DELAY_LAST  (DELAY_LAST)
   ) u_seq (
      .clk       (clk),
      .arm_raw   (arm_sw),
      .arm_s     (arm_s),
      .sens_s    (sens_s),
      .tick      (tick),
      .state     (state),
      .dly       (dly),
      .run_timer (run_timer),
      .siren     (siren)
   );

   sec_display #(
      .SEC_W      (SEC_W),
      .NUM_DIGITS (NUM_DIGITS),
      .LIVE_DIGIT (0)
   ) u_disp (
      .clk        (clk),
      .clr_n      (arm_sw),
      .run        (run_timer),
      .tick       (tick),
      .sec        (sec),
      .seg_n      (seg_n),
      .digit_en_n (digit_en_n)
   );

   assign ind_arm    = arm_sw;
   assign ind_front  = sens_front;
   assign ind_rear   = sens_rear;
   assign ind_window = sens_window;
endmodule

// File: rtl/alarm_checker.sv
module alarm_checker
   import alarm_pkg::*;
#(
   parameter int TICK_DIV   = 50_000_000,
   parameter int DELAY_W    = 3,
   parameter int DELAY_LAST = 7,
   parameter int SEC_W      = 4
) (
   input logic               clk,
   input logic               arm_raw,
   input logic               arm_s,
   input logic [2:0]         sens_s,
   input logic               tick,
   input alarm_state_e       state,
   input logic [DELAY_W-1:0] dly,
   input logic               run_timer,
   input logic               siren,
   input logic [SEC_W-1:0]   sec
);
   localparam logic [DELAY_W-1:0] LAST = DELAY_W'(DELAY_LAST);

   logic [31:0] gap_q;
   logic        seen_q;

   always_ff @(posedge clk or negedge arm_raw) begin
      if (!arm_raw) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (tick) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   p_arm_leaves_off_r2: assert property (@(posedge clk) disable iff (!arm_raw)
      (state == ST_OFF && arm_s) |=> state == ST_WATCH);

   p_quiet_stays_r2: assert property (@(posedge clk) disable iff (!arm_raw)
      (state == ST_WATCH && sens_s == 3'b000) |=> state == ST_WATCH);

   p_trip_enters_delay_r3: assert property (@(posedge clk) disable iff (!arm_raw)
      (state == ST_WATCH && sens_s != 3'b000) |=> state == ST_ENTRY);

   p_sec_step_r3: assert property (@(posedge clk) disable iff (!arm_raw)
      (run_timer && tick) |=> sec == $past(sec) + 1'b1);

   p_sec_zero_r3: assert property (@(posedge clk) disable iff (!arm_raw)
      !run_timer |=> sec == '0);

   p_delay_step_r4: assert property (@(posedge clk) disable iff (!arm_raw)
      (state == ST_ENTRY && tick && dly != LAST) |=> dly == $past(dly) + 1'b1);

   p_delay_clear_r4: assert property (@(posedge clk) disable iff (!arm_raw)
      (state != ST_ENTRY) |=> dly == '0);

   p_siren_source_r4: assert property (@(posedge clk) disable iff (!arm_raw)
      $rose(siren) |-> ($past(state) == ST_ENTRY && $past(dly) == LAST));

   p_alarm_latched_r5: assert property (@(posedge clk) disable iff (!arm_raw)
      (state == ST_SOUND && arm_s) |=> state == ST_SOUND);

   p_release_keeps_delay_r7: assert property (@(posedge clk) disable iff (!arm_raw)
      (state == ST_ENTRY && arm_s && dly != LAST) |=> state == ST_ENTRY);

   p_tick_pulse_r10: assert property (@(posedge clk) disable iff (!arm_raw)
      tick |=> !tick);

   p_tick_period_r10: assert property (@(posedge clk) disable iff (!arm_raw)
      (tick && seen_q) |-> gap_q == 32'(TICK_DIV - 1));
endmodule

bind intrusion_alarm_top alarm_checker #(
   .TICK_DIV   (TICK_DIV),
   .DELAY_W    (DELAY_W),
   .DELAY_LAST (DELAY_LAST),
   .SEC_W      (SEC_W)
) u_chk (
   .clk       (clk),
   .arm_raw   (arm_sw),
   .arm_s     (arm_s),
   .sens_s    (sens_s),
   .tick      (tick),
   .state     (state),
   .dly       (dly),
   .run_timer (run_timer),
   .siren     (siren),
   .sec       (sec)
);

// File: tb/tb_intrusion_alarm_top.sv
module tb_intrusion_alarm_top;
   localparam int DIV = 10;

   logic clk = 1'b0;
   logic arm_sw = 1'b0, sens_front = 1'b0, sens_rear = 1'b0, sens_window = 1'b0;
   logic siren, ind_arm, ind_front, ind_rear, ind_window;
   logic [7:0] seg_n;
   logic [3:0] digit_en_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   intrusion_alarm_top #(.TICK_DIV(DIV)) dut (
      .clk(clk), .arm_sw(arm_sw), .sens_front(sens_front), .sens_rear(sens_rear),
      .sens_window(sens_window), .siren(siren), .ind_arm(ind_arm), .ind_front(ind_front),
      .ind_rear(ind_rear), .ind_window(ind_window), .seg_n(seg_n), .digit_en_n(digit_en_n)
   );

   always #5 clk = ~clk;

   // expected active-low pattern, a..g,dp from MSB to LSB
   function automatic logic [7:0] exp_seg(input int d);
      case (d)
         0: return 8'h03;
         1: return 8'h9F;
         2: return 8'h25;
         3: return 8'h0D;
         4: return 8'h99;
         5: return 8'h49;
         6: return 8'h41;
         7: return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic set_sens(input logic [2:0] v);
      {sens_front, sens_rear, sens_window} = v;
   endtask

   task automatic quiet_disarmed(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         set_sens(3'($urandom_range(0, 7)));
         #1;
         check(siren == 1'b0, "R1", "siren while disarmed", siren, 0);
         check(seg_n == exp_seg(0), "R1", "display while disarmed", seg_n, exp_seg(0));
         check({ind_arm, ind_front, ind_rear, ind_window} ==
               {arm_sw, sens_front, sens_rear, sens_window}, "R8", "indicator echo",
               {ind_arm, ind_front, ind_rear, ind_window},
               {arm_sw, sens_front, sens_rear, sens_window});
      end
      @(negedge clk);
      set_sens(3'b000);
   endtask

   task automatic disarm_now(input string req);
      arm_sw = 1'b0;
      #1;
      check(siren == 1'b0, req, "siren right after disarm", siren, 0);
      check(seg_n == exp_seg(0), req, "display right after disarm", seg_n, exp_seg(0));
   endtask

   // one armed episode: trip, watch the delay, optionally disarm mid-way
   task automatic episode(input logic [2:0] pat, input int hold, input int disarm_at);
      int cycles, digit, last_change;
      bit aborted;
      @(negedge clk);
      arm_sw = 1'b1;
      set_sens(3'b000);
      repeat (4 + $urandom_range(0, 2 * DIV)) @(negedge clk);
      check(siren == 1'b0, "R2", "siren armed and quiet", siren, 0);
      check(seg_n == exp_seg(0), "R2", "display armed and quiet", seg_n, exp_seg(0));
      check(ind_arm == 1'b1, "R8", "arm echo", ind_arm, 1);
      set_sens(pat);
      cycles = 0; digit = 0; last_change = -1; aborted = 1'b0;
      while (cycles < 9 * DIV) begin
         @(negedge clk);
         cycles++;
         if (cycles == disarm_at) begin
            disarm_now("R6");
            aborted = 1'b1;
            break;
         end
         if (siren) break;
         if (seg_n != exp_seg(digit)) begin
            check(seg_n == exp_seg(digit + 1), "R3 R9", "next digit in delay",
                  seg_n, exp_seg(digit + 1));
            if (last_change >= 0)
               check(cycles - last_change == DIV, "R10", "tick spacing",
                     cycles - last_change, DIV);
            last_change = cycles;
            digit++;
         end
         if (cycles == hold) set_sens(3'b000);
      end
      if (!aborted) begin
         check(siren == 1'b1, "R4", "siren after delay", siren, 1);
         check(digit == 7, "R3", "last digit shown", digit, 7);
         check(cycles >= 6 * DIV && cycles <= 7 * DIV + 5, "R4", "siren cycle window",
               cycles, 7 * DIV);
         if (hold < cycles)
            check(siren == 1'b1, "R7", "delay survives sensor release", siren, 1);
         set_sens(3'b000);
         repeat (3 * DIV) @(negedge clk);
         check(siren == 1'b1, "R5", "siren latched", siren, 1);
         check(seg_n == exp_seg(0), "R5", "display back to 0 in alarm", seg_n, exp_seg(0));
         disarm_now("R6");
      end
      set_sens(3'b000);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_A1A3));
      repeat (3) @(negedge clk);
      #1;
      check(siren == 1'b0, "R1", "reset siren", siren, 0);
      check(seg_n == exp_seg(0), "R1 R9", "reset display", seg_n, exp_seg(0));
      check(digit_en_n == 4'b1110, "R1", "digit enables", digit_en_n, 4'hE);
      quiet_disarmed(20);

      // directed corners: each single sensor, all sensors, short pulse, late disarm
      episode(3'b100, 2, -1);
      episode(3'b010, 3 * DIV, -1);
      episode(3'b001, 100 * DIV, -1);
      episode(3'b111, 2, 6 * DIV);
      episode(3'b101, 5, 2);

      for (int e = 0; e < 30; e++) begin
         logic [2:0] pat;
         int hold, dis;
         pat  = 3'($urandom_range(1, 7));
         hold = $urandom_range(2, 8 * DIV);
         dis  = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 7 * DIV) : -1;
         episode(pat, hold, dis);
         quiet_disarmed(4);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule